// File: doc/BRIEF.md
# Hypervisor Trap Entry Controller

This block watches the data bus of an 8-bit CPU core for accesses to a 64-byte hypervisor register window at 0xD640..0xD67F. A write into that window while the core runs in user mode turns into a trap. On the clock edge that ends the write, the block copies the live CPU registers into a shadow set and raises hypervisor mode. It then tells the program-counter sequencer to jump to an entry address. That address is built by shifting the low six bits of the trapping address left by two, which gives one 4-byte slot per window location. Hardware reset gets its own entry at 0x8100, outside all trap slots, so a handler never mistakes a reset for a trap.

Inside hypervisor mode the same window is a plain register file. Fixed offsets read and write the saved A, X, Y, Z, B, P, stack pointer and return PC, so the handler can inspect or alter the state it will return to. Writes to the window never trap in this mode, so nesting cannot happen. A write to the top window offset ends the handler. The shadow set is then presented for loading back into the core, hypervisor mode drops, and the PC is sent back to the saved address. A one-bit upgrade marker is also held in the window. It can be set once, survives CPU reset, and only the power-on reset input clears it.

Top module: `hv_trap_ctrl`

## Requirements
- R1: Only a write (bus_we_i=1) whose address lies in 0xD640..0xD67F traps, and only in user mode. Writes at 0xD63F or 0xD680 leave hypervisor mode and the trap strobe unchanged.
- R2: The cycle after a trapping write shows trap_o=1, hv_mode_o=1 and pc_load_o=1, with pc_addr_o = 0x8000 + 4*(address bits 5:0). trap_o lasts exactly one cycle.
- R3: While CPU reset or power-on reset is asserted, and in the first cycle after release, the outputs are hv_mode_o=1, pc_load_o=1 and pc_addr_o=0x8100. pc_load_o then falls on the first edge after release.
- R4: A trap copies cpu_a_i, cpu_x_i, cpu_y_i, cpu_z_i, cpu_b_i, cpu_sp_i, cpu_p_i and cpu_pc_i (the next-instruction address) into the shadow set. In hypervisor mode, a read (bus_re_i=1) returns the saved byte on bus_rdata_o in the same cycle. Offset 0 holds A, 1 holds X, 2 holds Y, 3 holds Z, 4 holds B, 5 and 6 hold SP low and high, 7 holds P, and 8 and 9 hold PC low and high. Offsets 0x0A..0x3D read 0.
- R5: In hypervisor mode, a write to offsets 0..9 replaces that shadow byte and never raises trap_o.
- R6: In hypervisor mode, a write to offset 0x3F gives, in the next cycle, hv_mode_o=0, restore_o=1 for one cycle, and pc_load_o=1 with pc_addr_o equal to the saved PC. The sh_*_o outputs carry the shadow values for the core to load.
- R7: In user mode, a window read returns the saved PC high byte, raises no trap and leaves hv_mode_o at 0.
- R8: In hypervisor mode, a write to offset 0x3E with data bit 0 = 1 sets upgrade_o. That offset reads back {7'b0, flag}. Once set, further writes have no effect. CPU reset leaves it set, and only por_ni low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | CPU reset, active low |
| por_ni | input | 1 | Power-on reset, active low |
| bus_addr_i | input | 16 | CPU bus address |
| bus_wdata_i | input | 8 | CPU write data |
| bus_we_i | input | 1 | Write cycle |
| bus_re_i | input | 1 | Read cycle |
| bus_rdata_o | output | 8 | Window read data, 0 outside window |
| cpu_a_i | input | 8 | Live A register |
| cpu_x_i | input | 8 | Live X register |
| cpu_y_i | input | 8 | Live Y register |
| cpu_z_i | input | 8 | Live Z register |
| cpu_b_i | input | 8 | Live B register |
| cpu_sp_i | input | 16 | Live stack pointer |
| cpu_p_i | input | 8 | Live status flags |
| cpu_pc_i | input | 16 | Address of next instruction |
| hv_mode_o | output | 1 | Hypervisor mode |
| trap_o | output | 1 | One-cycle trap strobe |
| restore_o | output | 1 | One-cycle restore strobe |
| pc_load_o | output | 1 | Load PC from pc_addr_o |
| pc_addr_o | output | 16 | PC target |
| sh_a_o | output | 8 | Shadow A |
| sh_x_o | output | 8 | Shadow X |
| sh_y_o | output | 8 | Shadow Y |
| sh_z_o | output | 8 | Shadow Z |
| sh_b_o | output | 8 | Shadow B |
| sh_sp_o | output | 16 | Shadow SP |
| sh_p_o | output | 8 | Shadow P |
| sh_pc_o | output | 16 | Shadow PC |
| upgrade_o | output | 1 | Write-once upgrade marker |

## Verification
The bench sweeps all 64 window offsets. Each pass loads the live registers with an offset-dependent pattern, traps, reads back every shadow byte and returns. A wrong shift or vector base would show up as an entry address that skips slots or lands on 0x8100. A swapped shadow offset would show one register's byte where another's belongs. The bench also writes at the two addresses just outside the window, where a loose decoder would trap falsely. It modifies the shadow set before returning, so a return that reloads stale or live values would be caught. Finally, it pulses CPU reset and then power-on reset after setting the upgrade marker. A marker tied to the wrong reset would either vanish early or outlive power-on.

// File: rtl/hv_pkg.sv
package hv_pkg;
    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [7:0]  z;
        logic [7:0]  b;
        logic [15:0] sp;
        logic [7:0]  p;
        logic [15:0] pc;
    } shadow_t;

    localparam int SH_A   = 0;
    localparam int SH_X   = 1;
    localparam int SH_Y   = 2;
    localparam int SH_Z   = 3;
    localparam int SH_B   = 4;
    localparam int SH_SPL = 5;
    localparam int SH_SPH = 6;
    localparam int SH_P   = 7;
    localparam int SH_PCL = 8;
    localparam int SH_PCH = 9;
endpackage

// File: rtl/hv_win_dec.sv
module hv_win_dec #(
    parameter logic [15:0] BASE = 16'hD640,
    parameter int          BITS = 6
) (
    input  logic [15:0]     addr_i,
    output logic            hit_o,
    output logic [BITS-1:0] off_o
);
    localparam int TAG_W = 16 - BITS;

    assign hit_o = (addr_i[15:BITS] == BASE[15:BITS]);
    assign off_o = addr_i[BITS-1:0];
    logic unused_base;
    assign unused_base = ^BASE[BITS-1:0];
    localparam int UNUSED_TAG = TAG_W;
endmodule

// File: rtl/hv_sticky_flag.sv
module hv_sticky_flag (
    input  logic clk_i,
    input  logic por_ni,
    input  logic set_i,
    output logic q_o
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q | set_i;
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) q_q <= 1'b0;
        else         q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/hv_trap_ctrl.sv
module hv_trap_ctrl
    import hv_pkg::*;
#(
    parameter logic [15:0] WIN_BASE  = 16'hD640,
    parameter int          WIN_BITS  = 6,
    parameter logic [15:0] TRAP_BASE = 16'h8000,
    parameter logic [15:0] RESET_VEC = 16'h8100,
    parameter int          VEC_SHIFT = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        por_ni,
    input  logic [15:0] bus_addr_i,
    input  logic [7:0]  bus_wdata_i,
    input  logic        bus_we_i,
    input  logic        bus_re_i,
    output logic [7:0]  bus_rdata_o,
    input  logic [7:0]  cpu_a_i,
    input  logic [7:0]  cpu_x_i,
    input  logic [7:0]  cpu_y_i,
    input  logic [7:0]  cpu_z_i,
    input  logic [7:0]  cpu_b_i,
    input  logic [15:0] cpu_sp_i,
    input  logic [7:0]  cpu_p_i,
    input  logic [15:0] cpu_pc_i,
    output logic        hv_mode_o,
    output logic        trap_o,
    output logic        restore_o,
    output logic        pc_load_o,
    output logic [15:0] pc_addr_o,
    output logic [7:0]  sh_a_o,
    output logic [7:0]  sh_x_o,
    output logic [7:0]  sh_y_o,
    output logic [7:0]  sh_z_o,
    output logic [7:0]  sh_b_o,
    output logic [15:0] sh_sp_o,
    output logic [7:0]  sh_p_o,
    output logic [15:0] sh_pc_o,
    output logic        upgrade_o
);
    localparam logic [WIN_BITS-1:0] RET_OFF  = {WIN_BITS{1'b1}};
    localparam logic [WIN_BITS-1:0] FLAG_OFF = RET_OFF - 1'b1;

    typedef struct packed {
        logic        hv;
        logic        trap;
        logic        restore;
        logic        pc_load;
        logic [15:0] pc_addr;
        shadow_t     sh;
    } state_t;

    state_t st_d, st_q;
    logic                win_hit;
    logic [WIN_BITS-1:0] win_off;
    logic                win_wr;
    logic                flag_set_d;
    logic                flag_q;
    logic                core_rst_n;

    assign core_rst_n = rst_ni & por_ni;

    hv_win_dec #(.BASE(WIN_BASE), .BITS(WIN_BITS)) u_dec (
        .addr_i (bus_addr_i),
        .hit_o  (win_hit),
        .off_o  (win_off)
    );

    hv_sticky_flag u_flag (
        .clk_i  (clk_i),
        .por_ni (por_ni),
        .set_i  (flag_set_d),
        .q_o    (flag_q)
    );

    assign win_wr = bus_we_i & win_hit;

    always_comb begin
        st_d         = st_q;
        st_d.trap    = 1'b0;
        st_d.restore = 1'b0;
        st_d.pc_load = 1'b0;
        flag_set_d   = 1'b0;
        if (win_wr && !st_q.hv) begin
            st_d.trap    = 1'b1;
            st_d.hv      = 1'b1;
            st_d.pc_load = 1'b1;
            st_d.pc_addr = TRAP_BASE + (16'(win_off) << VEC_SHIFT);
            st_d.sh      = '{a: cpu_a_i, x: cpu_x_i, y: cpu_y_i, z: cpu_z_i,
                             b: cpu_b_i, sp: cpu_sp_i, p: cpu_p_i, pc: cpu_pc_i};
        end else if (win_wr) begin
            if (win_off == RET_OFF) begin
                st_d.hv      = 1'b0;
                st_d.restore = 1'b1;
                st_d.pc_load = 1'b1;
                st_d.pc_addr = st_q.sh.pc;
            end else if (win_off == FLAG_OFF) begin
                flag_set_d = bus_wdata_i[0];
            end else begin
                case (int'(win_off))
                    SH_A:    st_d.sh.a        = bus_wdata_i;
                    SH_X:    st_d.sh.x        = bus_wdata_i;
                    SH_Y:    st_d.sh.y        = bus_wdata_i;
                    SH_Z:    st_d.sh.z        = bus_wdata_i;
                    SH_B:    st_d.sh.b        = bus_wdata_i;
                    SH_SPL:  st_d.sh.sp[7:0]  = bus_wdata_i;
                    SH_SPH:  st_d.sh.sp[15:8] = bus_wdata_i;
                    SH_P:    st_d.sh.p        = bus_wdata_i;
                    SH_PCL:  st_d.sh.pc[7:0]  = bus_wdata_i;
                    SH_PCH:  st_d.sh.pc[15:8] = bus_wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge core_rst_n) begin
        if (!core_rst_n) begin
            st_q         <= '0;
            st_q.hv      <= 1'b1;
            st_q.pc_load <= 1'b1;
            st_q.pc_addr <= RESET_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = 8'h00;
        if (bus_re_i && win_hit) begin
            if (!st_q.hv) begin
                bus_rdata_o = st_q.sh.pc[15:8];
            end else if (win_off == FLAG_OFF) begin
                bus_rdata_o = {7'b0, flag_q};
            end else begin
                case (int'(win_off))
                    SH_A:    bus_rdata_o = st_q.sh.a;
                    SH_X:    bus_rdata_o = st_q.sh.x;
                    SH_Y:    bus_rdata_o = st_q.sh.y;
                    SH_Z:    bus_rdata_o = st_q.sh.z;
                    SH_B:    bus_rdata_o = st_q.sh.b;
                    SH_SPL:  bus_rdata_o = st_q.sh.sp[7:0];
                    SH_SPH:  bus_rdata_o = st_q.sh.sp[15:8];
                    SH_P:    bus_rdata_o = st_q.sh.p;
                    SH_PCL:  bus_rdata_o = st_q.sh.pc[7:0];
                    SH_PCH:  bus_rdata_o = st_q.sh.pc[15:8];
                    default: bus_rdata_o = 8'h00;
                endcase
            end
        end
    end

    assign hv_mode_o = st_q.hv;
    assign trap_o    = st_q.trap;
    assign restore_o = st_q.restore;
    assign pc_load_o = st_q.pc_load;
    assign pc_addr_o = st_q.pc_addr;
    assign sh_a_o    = st_q.sh.a;
    assign sh_x_o    = st_q.sh.x;
    assign sh_y_o    = st_q.sh.y;
    assign sh_z_o    = st_q.sh.z;
    assign sh_b_o    = st_q.sh.b;
    assign sh_sp_o   = st_q.sh.sp;
    assign sh_p_o    = st_q.sh.p;
    assign sh_pc_o   = st_q.sh.pc;
    assign upgrade_o = flag_q;
endmodule

// File: rtl/hv_trap_chk.sv
module hv_trap_chk #(
    parameter logic [15:0] TRAP_BASE = 16'h8000
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        por_ni,
    input logic [15:0] bus_addr_i,
    input logic        bus_we_i,
    input logic        hv_mode_o,
    input logic        trap_o,
    input logic        restore_o,
    input logic        pc_load_o,
    input logic [15:0] pc_addr_o,
    input logic        upgrade_o
);
    // R2
    trap_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> !trap_o);

    // R2
    trap_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> (hv_mode_o && pc_load_o &&
                    pc_addr_o == TRAP_BASE + {8'h00, $past(bus_addr_i[5:0]), 2'b00}));

    // R1
    trap_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> $past(bus_we_i));

    // R5
    no_nested_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> !$past(hv_mode_o));

    // R6
    restore_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restore_o |-> (!hv_mode_o && pc_load_o && $past(hv_mode_o)));

    // R8
    upgrade_sticky_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        upgrade_o |=> upgrade_o);
endmodule

bind hv_trap_ctrl hv_trap_chk #(.TRAP_BASE(TRAP_BASE)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni & por_ni),
    .por_ni     (por_ni),
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .hv_mode_o  (hv_mode_o),
    .trap_o     (trap_o),
    .restore_o  (restore_o),
    .pc_load_o  (pc_load_o),
    .pc_addr_o  (pc_addr_o),
    .upgrade_o  (upgrade_o)
);

// File: tb/sim_hv_trap_ctrl.sv
module sim_hv_trap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  ca = 0, cx = 0, cy = 0, cz = 0, cb = 0, cp = 0;
    logic [15:0] csp = 0, cpc = 0;
    logic        hv, trap, rest, pcl, upg;
    logic [15:0] pca;
    logic [7:0]  sa, sx, sy, sz, sb, sp8;
    logic [15:0] ssp, spc;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    hv_trap_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
        .bus_rdata_o(rdata),
        .cpu_a_i(ca), .cpu_x_i(cx), .cpu_y_i(cy), .cpu_z_i(cz), .cpu_b_i(cb),
        .cpu_sp_i(csp), .cpu_p_i(cp), .cpu_pc_i(cpc),
        .hv_mode_o(hv), .trap_o(trap), .restore_o(rest), .pc_load_o(pcl),
        .pc_addr_o(pca),
        .sh_a_o(sa), .sh_x_o(sx), .sh_y_o(sy), .sh_z_o(sz), .sh_b_o(sb),
        .sh_sp_o(ssp), .sh_p_o(sp8), .sh_pc_o(spc), .upgrade_o(upg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        #1;
        d = rdata;
        re = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv;
        // R3 reset entry
        #20;
        chk("R3 hv in reset", hv, 1);
        chk("R3 pc_load in reset", pcl, 1);
        chk("R3 reset vector", pca, 16'h8100);
        chk("R8 flag clear at power-on", upg, 0);
        @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
        chk("R3 vector held after release", pca, 16'h8100);
        idle();
        chk("R3 pc_load drops", pcl, 0);
        chk("R3 still hv", hv, 1);

        // R4 unmapped reads, R8 flag readback
        bus_rd(16'hD660, rv); chk("R4 unmapped offset", rv, 0);
        bus_rd(16'hD67E, rv); chk("R8 flag readback 0", rv, 0);

        // R5 hypervisor writes edit shadow
        bus_wr(16'hD640, 8'h5A);
        chk("R5 no trap in hv", trap, 0);
        bus_rd(16'hD640, rv); chk("R5 shadow A written", rv, 8'h5A);
        bus_wr(16'hD648, 8'h45);
        bus_wr(16'hD649, 8'h23);
        bus_wr(16'hD646, 8'hBE);
        chk("R5 still hv", hv, 1);

        // R6 return
        bus_wr(16'hD67F, 8'h00);
        chk("R6 hv cleared", hv, 0);
        chk("R6 restore strobe", rest, 1);
        chk("R6 pc_load", pcl, 1);
        chk("R6 return pc", pca, 16'h2345);
        chk("R6 shadow A out", sa, 8'h5A);
        chk("R6 shadow SP out", ssp, 16'hBE00);
        idle();
        chk("R6 restore one cycle", rest, 0);

        // R7 user read
        bus_rd(16'hD645, rv);
        chk("R7 user read value", rv, 8'h23);
        idle();
        chk("R7 no trap", trap, 0);
        chk("R7 stays user", hv, 0);

        // R1 boundaries
        bus_wr(16'hD63F, 8'h11);
        chk("R1 below window", trap, 0);
        chk("R1 below window hv", hv, 0);
        bus_wr(16'hD680, 8'h11);
        chk("R1 above window", trap, 0);
        chk("R1 above window hv", hv, 0);
        @(negedge clk); addr = 16'hD650; re = 1'b1;
        @(negedge clk); re = 1'b0;
        chk("R1 read does not trap", hv, 0);

        // R2/R4/R6 sweep over all offsets
        for (int k = 0; k < 64; k++) begin
            logic [7:0] kb;
            kb = 8'(k);
            ca = kb; cx = kb ^ 8'h55; cy = kb + 8'd1; cz = ~kb; cb = kb ^ 8'hA0;
            csp = {kb, ~kb}; cp = kb * 8'd3; cpc = 16'h1000 + 16'(k * 7);
            bus_wr(16'hD640 + 16'(k), 8'hFF);
            chk("R2 trap strobe", trap, 1);
            chk("R2 hv set", hv, 1);
            chk("R2 entry address", pca, 16'h8000 + 16'(4 * k));
            idle();
            chk("R2 strobe one cycle", trap, 0);
            ca = 0; cx = 0; cy = 0; cz = 0; cb = 0; csp = 0; cp = 0; cpc = 0;
            bus_rd(16'hD640, rv); chk("R4 A", rv, kb);
            bus_rd(16'hD641, rv); chk("R4 X", rv, kb ^ 8'h55);
            bus_rd(16'hD642, rv); chk("R4 Y", rv, 8'(kb + 8'd1));
            bus_rd(16'hD643, rv); chk("R4 Z", rv, 8'(~kb));
            bus_rd(16'hD644, rv); chk("R4 B", rv, kb ^ 8'hA0);
            bus_rd(16'hD645, rv); chk("R4 SP low", rv, 8'(~kb));
            bus_rd(16'hD646, rv); chk("R4 SP high", rv, kb);
            bus_rd(16'hD647, rv); chk("R4 P", rv, 8'(kb * 8'd3));
            bus_rd(16'hD648, rv); chk("R4 PC low", rv, 8'(16'h1000 + 16'(k * 7)));
            bus_rd(16'hD649, rv); chk("R4 PC high", rv, 8'((16'h1000 + 16'(k * 7)) >> 8));
            if (k == 63) break;
            bus_wr(16'hD67F, 8'h00);
            chk("R6 sweep return pc", pca, 16'h1000 + 16'(k * 7));
            chk("R6 sweep hv cleared", hv, 0);
            chk("R6 sweep shadow X out", sx, kb ^ 8'h55);
        end

        // R8 write-once flag (still in hv from final trap)
        bus_wr(16'hD67E, 8'h00);
        chk("R8 zero write no set", upg, 0);
        bus_wr(16'hD67E, 8'h01);
        chk("R8 set", upg, 1);
        bus_wr(16'hD67E, 8'h00);
        chk("R8 write ignored once set", upg, 1);
        bus_rd(16'hD67E, rv); chk("R8 readback 1", rv, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 survives CPU reset", upg, 1);
        chk("R3 CPU reset vector", pca, 16'h8100);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R8 cleared by power-on", upg, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule